// File: doc/BRIEF.md
# Bidirectional registered bus transceiver

This block joins two 18-bit buses, side A and side B, and moves data between them in either direction. Each direction has a single storage stage with three ways of working. In pass-through mode the output side follows the input side within the same cycle. In hold mode the output keeps the last stored value. In strobe-capture mode the stage loads the input side when that direction's strobe falls. Each direction also has its own output enable, which either drives the far bus or releases it. The A-to-B enable is active high and the B-to-A enable is active low.

The two directions share nothing except the sampling clock and the reset. The direction strobes are ordinary inputs, and the sampling clock looks for their high-to-low transitions. A falling strobe is seen only if the strobe is high at one rising `clk` edge and low at the next.

The pads are modelled in two ways. The inout ports are released to high impedance when their direction is disabled, and two plain flags report which side the block is driving. This block has no streaming traffic, so it has no valid/ready handshake. Every pin is a plain level. The system that drives the bus must never enable both directions at once.

Top module: `bidir_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage stages are zero. After reset, with pass low and the A-to-B enable high, `port_b` reads 0 and `a_driving` is 0.
- R2: While `ab_pass` is 1, `port_b` equals `port_a` in the same cycle, with no clock edge needed.
- R3: While `ab_pass` is 0 and `ab_strobe` is not falling, the A-to-B stored value does not change, whatever `port_a` does. This holds whether the strobe is held low or held high.
- R4: While `ab_pass` is 0, a falling `ab_strobe` loads `port_a` into storage at the rising `clk` edge where the fall is seen. From then on, `port_b` shows that value.
- R5: A rising `ab_strobe` does not load storage.
- R6: While `ab_oe` is 0, `b_driving` is 0 and `port_b` is released.
- R7: The B-to-A direction behaves like R2 to R5, using `ba_pass` and `ba_strobe`. It drives `port_a` and raises `a_driving` only while `ba_oe_n` is 0.
- R8: When pass falls while the strobe is low, storage keeps the last input value sampled while pass was high.
- R9: While pass is high, a falling strobe has no effect, and the output keeps following the input.
- R10: Storage keeps updating while its outputs are released. Enabling the outputs later shows the stored value at once.
- R11: Asserting `rst_n` low clears both stages immediately, with no clock edge.
- R12: Activity in one direction never changes the stored value of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; storage updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both stages |
| ab_pass | input | 1 | A-to-B pass-through select (1 = transparent) |
| ab_strobe | input | 1 | A-to-B capture strobe; a falling edge loads storage |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_pass | input | 1 | B-to-A pass-through select (1 = transparent) |
| ba_strobe | input | 1 | B-to-A capture strobe; a falling edge loads storage |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| port_a | inout | 18 | Side A bus |
| port_b | inout | 18 | Side B bus |
| a_driving | output | 1 | 1 while the block drives `port_a` |
| b_driving | output | 1 | 1 while the block drives `port_b` |

## Verification
The bench targets the corners where a storage stage might pick the wrong value:
- Pass falls while the strobe is low. A design that latched one cycle late would keep the newer input here.
- The strobe falls while pass is high. A design that let the strobe win would freeze the output.
- The strobe rises. A design that captured on both edges would load on the rise.
- The input changes while the strobe is held high. A design that treated a high strobe as transparent would follow the input.

It also checks three more behaviours:
- Storage loads while the outputs are released. A design that gated the load with the enable would show stale data when the outputs are enabled.
- Reset is asynchronous and clears both stages before any clock edge.
- One direction's traffic leaves the other direction's stored value alone.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_W = 18;

  typedef struct packed {
    logic pass;
    logic strobe;
    logic oe_raw;
  } lane_ctl_t;
endpackage

// File: rtl/xcvr_lane_store.sv
module xcvr_lane_store #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pass,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] held;
  logic         strobe_q;
  logic         strobe_fall;

  assign strobe_fall = strobe_q & ~strobe;

  // Storage tracks the input while transparent; otherwise loads only on a seen falling strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (pass || strobe_fall) held <= din;
    end
  end

  assign dout = pass ? din : held;
endmodule

// File: rtl/xcvr_lane_drive.sv
module xcvr_lane_drive #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic oe_raw,
  output logic drive_en
);
  generate
    if (ACTIVE_LOW) begin : g_low
      assign drive_en = ~oe_raw;
    end else begin : g_high
      assign drive_en = oe_raw;
    end
  endgenerate
endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ab_oe,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  input  logic         ba_oe_n,
  inout  wire  [W-1:0] port_a,
  inout  wire  [W-1:0] port_b,
  output logic         a_driving,
  output logic         b_driving
);
  localparam int NDIR = 2;

  lane_ctl_t    ctl  [NDIR];
  logic [W-1:0] src  [NDIR];
  logic [W-1:0] val  [NDIR];
  logic         en   [NDIR];
  logic [W-1:0] ab_val;
  logic [W-1:0] ba_val;

  assign ctl[0] = '{pass: ab_pass, strobe: ab_strobe, oe_raw: ab_oe};
  assign ctl[1] = '{pass: ba_pass, strobe: ba_strobe, oe_raw: ba_oe_n};
  assign src[0] = port_a;
  assign src[1] = port_b;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_lane_store #(.W(W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .pass   (ctl[d].pass),
      .strobe (ctl[d].strobe),
      .din    (src[d]),
      .dout   (val[d])
    );
    xcvr_lane_drive #(.ACTIVE_LOW(d == 1)) u_drive (
      .oe_raw   (ctl[d].oe_raw),
      .drive_en (en[d])
    );
  end

  assign ab_val    = val[0];
  assign ba_val    = val[1];
  assign b_driving = en[0];
  assign a_driving = en[1];

  assign port_b = b_driving ? ab_val : {W{1'bz}};
  assign port_a = a_driving ? ba_val : {W{1'bz}};
endmodule

// File: rtl/bidir_xcvr_chk.sv
module bidir_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ab_pass,
  input logic         ab_strobe,
  input logic         ba_pass,
  input logic         ba_strobe,
  input logic [W-1:0] port_a,
  input logic [W-1:0] port_b,
  input logic [W-1:0] ab_val,
  input logic [W-1:0] ba_val
);
  logic armed, ab_prev, ba_prev;
  logic ab_fall, ba_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      ab_prev <= 1'b0;
      ba_prev <= 1'b0;
    end else begin
      armed   <= 1'b1;
      ab_prev <= ab_strobe;
      ba_prev <= ba_strobe;
    end
  end

  assign ab_fall = ab_prev & ~ab_strobe;
  assign ba_fall = ba_prev & ~ba_strobe;

  // R3: no load without a falling strobe while pass is low
  a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ab_pass && !ab_fall) |=> (ab_pass || $stable(ab_val)));

  // R4: a falling strobe loads the A side
  a_r4_fall_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ab_pass && ab_fall) |=> (ab_pass || ab_val == $past(port_a)));

  // R8: dropping pass keeps the last tracked input
  a_r8_last_tracked: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed) && $fell(ab_pass)) |-> ab_val == $past(port_a));

  // R7: reverse direction loads the B side on its falling strobe
  a_r7_rev_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ba_pass && ba_fall) |=> (ba_pass || ba_val == $past(port_b)));
endmodule

bind bidir_xcvr bidir_xcvr_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ab_pass   (ab_pass),
  .ab_strobe (ab_strobe),
  .ba_pass   (ba_pass),
  .ba_strobe (ba_strobe),
  .port_a    (port_a),
  .port_b    (port_b),
  .ab_val    (ab_val),
  .ba_val    (ba_val)
);

// File: tb/bidir_xcvr_tb.sv
module bidir_xcvr_tb;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n, ab_pass, ab_strobe, ab_oe, ba_pass, ba_strobe, ba_oe_n;
  logic tb_a_en, tb_b_en;
  logic [W-1:0] tb_a, tb_b;
  logic a_driving, b_driving;
  wire  [W-1:0] bus_a, bus_b;

  assign bus_a = tb_a_en ? tb_a : {W{1'bz}};
  assign bus_b = tb_b_en ? tb_b : {W{1'bz}};

  always #10 clk = ~clk;

  bidir_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_oe(ab_oe),
    .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_oe_n(ba_oe_n),
    .port_a(bus_a), .port_b(bus_b),
    .a_driving(a_driving), .b_driving(b_driving)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // scoreboard queues: side (0 = B output, 1 = A output), value, drive flag, tag
  bit           sb_side [$];
  logic [W-1:0] sb_val  [$];
  bit           sb_drv  [$];
  string        sb_tag  [$];
  event         mon_ev;

  task automatic expect_pin(input bit side, input logic [W-1:0] v, input bit drv, input string tag);
    #2;
    sb_side.push_back(side);
    sb_val.push_back(v);
    sb_drv.push_back(drv);
    sb_tag.push_back(tag);
    -> mon_ev;
    #1;
  endtask

  task automatic after_rise();
    @(posedge clk);
    #5;
  endtask

  // monitor: pops expectations and compares against the pins
  initial begin
    forever begin
      @(mon_ev);
      while (sb_side.size() > 0) begin
        bit           s;
        logic [W-1:0] v;
        bit           d;
        string        t;
        logic         got_d;
        logic [W-1:0] got_v;
        s = sb_side.pop_front();
        v = sb_val.pop_front();
        d = sb_drv.pop_front();
        t = sb_tag.pop_front();
        got_d = s ? a_driving : b_driving;
        got_v = s ? bus_a : bus_b;
        n_cmp++;
        if (got_d !== d || (d && got_v !== v)) begin
          n_bad++;
          $display("FAIL %s: drive=%0b value=%05h, expected drive=%0b value=%05h",
                   t, got_d, got_v, d, v);
        end
      end
    end
  end

  // both directions driving at once is a bus fight
  always @(posedge clk) begin
    if (rst_n && ab_oe && !ba_oe_n) begin
      n_bad++;
      $display("FAIL contention: ab_oe=%0b ba_oe_n=%0b, expected not both enabled", ab_oe, ba_oe_n);
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ab_pass = 0; ab_strobe = 0; ab_oe = 1;
    ba_pass = 0; ba_strobe = 0; ba_oe_n = 1;
    tb_a_en = 1; tb_a = '0; tb_b_en = 0; tb_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    expect_pin(0, 18'h00000, 1, "R1 reset value on B");
    expect_pin(1, 18'h00000, 0, "R1 A side released");

    // R2 pass-through
    @(negedge clk) begin ab_pass = 1; tb_a = 18'h01234; end
    expect_pin(0, 18'h01234, 1, "R2 transparent");
    tb_a = 18'h3ABCD;
    expect_pin(0, 18'h3ABCD, 1, "R2 transparent follow");

    // R9 strobe fall while transparent
    @(negedge clk) begin tb_a = 18'h2AAAA; ab_strobe = 1; end
    @(negedge clk) ab_strobe = 0;
    after_rise();
    expect_pin(0, 18'h2AAAA, 1, "R9 strobe fall under pass");
    tb_a = 18'h00F0F;
    expect_pin(0, 18'h00F0F, 1, "R9 still following");

    // R8 pass falls with strobe low
    @(negedge clk) tb_a = 18'h11111;
    @(negedge clk) begin ab_pass = 0; tb_a = 18'h22222; end
    after_rise();
    expect_pin(0, 18'h11111, 1, "R8 last tracked value");

    // R3 hold with strobe low
    @(negedge clk) tb_a = 18'h2C3C3;
    after_rise();
    expect_pin(0, 18'h11111, 1, "R3 hold strobe low");
    after_rise();
    expect_pin(0, 18'h11111, 1, "R3 hold strobe low later");

    // R5 rising strobe does not load
    @(negedge clk) begin ab_strobe = 1; tb_a = 18'h33333; end
    after_rise();
    expect_pin(0, 18'h11111, 1, "R5 rising strobe");
    @(negedge clk) tb_a = 18'h04444;
    after_rise();
    expect_pin(0, 18'h11111, 1, "R3 hold strobe high");

    // R4 falling strobe loads
    @(negedge clk) begin tb_a = 18'h05555; ab_strobe = 0; end
    after_rise();
    expect_pin(0, 18'h05555, 1, "R4 falling strobe load");
    @(negedge clk) tb_a = 18'h06666;
    after_rise();
    expect_pin(0, 18'h05555, 1, "R4 value kept after load");

    // R6 output release
    @(negedge clk) ab_oe = 0;
    expect_pin(0, 18'h00000, 0, "R6 B released");

    // R10 load while released
    @(negedge clk) ab_strobe = 1;
    @(negedge clk) begin tb_a = 18'h07777; ab_strobe = 0; end
    after_rise();
    @(negedge clk) ab_oe = 1;
    expect_pin(0, 18'h07777, 1, "R10 stored while released");

    // R7 reverse direction
    @(negedge clk) begin ab_oe = 0; tb_a_en = 0; tb_b_en = 1; tb_b = 18'h0ABCD; end
    expect_pin(1, 18'h00000, 0, "R7 A released with ba_oe_n high");
    @(negedge clk) begin ba_oe_n = 0; ba_pass = 1; end
    expect_pin(1, 18'h0ABCD, 1, "R7 reverse transparent");
    @(negedge clk) begin ba_pass = 0; tb_b = 18'h0FFFF; end
    after_rise();
    expect_pin(1, 18'h0ABCD, 1, "R7 reverse hold");
    @(negedge clk) ba_strobe = 1;
    @(negedge clk) begin tb_b = 18'h12345; ba_strobe = 0; end
    after_rise();
    expect_pin(1, 18'h12345, 1, "R7 reverse strobe load");

    // R12 independence
    @(negedge clk) begin ba_oe_n = 1; tb_b_en = 0; tb_a_en = 1; tb_a = 18'h3FFFF; end
    #1 ab_oe = 1;
    expect_pin(0, 18'h07777, 1, "R12 A-to-B untouched by reverse traffic");

    // R11 asynchronous reset
    @(negedge clk) #3 rst_n = 0;
    expect_pin(0, 18'h00000, 1, "R11 async clear A-to-B");
    @(negedge clk) begin ab_oe = 0; tb_a_en = 0; end
    #1 ba_oe_n = 0;
    expect_pin(1, 18'h00000, 1, "R11 async clear B-to-A");
    @(negedge clk) ba_oe_n = 1;
    rst_n = 1;
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule